// File: doc/BRIEF.md
# I/O Page Decoder with Video Lockout

This block watches a 24-bit CPU address bus and turns each access into one registered chip select. The I/O region is decoded in 256-byte pages: only address bits 23 down to 8 take part, except inside the two lock pages, where a few low bits limit the select to the register bytes. A video-processor select is decoded with a sparse mask, so the same registers repeat many times across the 0xC00000 to 0xDFFFFF window. Peripherals are not part of this block. It only produces their selects.

A lock register, cleared at power-up, gates the video window. While it does not hold the unlock key, any access anywhere in 0xC00000 to 0xDFFFFF latches a lockout. The access that triggers it still gets its video select, so a write there lands. From the next cycle on, the CPU reset and halt outputs stay high and every select is forced low. The external reset-button input cannot clear the lockout. Only the power-on reset `rst` clears it.

All outputs are registered. An access sampled at rising edge k shows on the select outputs after edge k. A lockout caused by that access shows on `cpu_reset` and `cpu_halt` after edge k+1.

Top module: `io_page_decoder`

## Requirements
- R1: With `bus_valid` high, these addresses each raise exactly one select: 0xA00000 to 0xA0FFFF gives `sel_sound`, page 0xA100xx gives `sel_io`, page 0xA110xx gives `sel_refresh`, page 0xA111xx gives `sel_busreq`, page 0xA112xx gives `sel_sndrst`, and page 0xA130xx gives `sel_timer`. At most one of the select outputs other than `exp_wr` is high in any cycle. With `bus_valid` low, no select is raised.
- R2: `sel_video` asserts exactly when (address AND 0xE700E0) equals 0xC00000. The mirrors at 0xC80000, 0xD00000 and 0xD8001F are selected. 0xC00020 and 0xE00000 are not.
- R3: Page 0xA113xx raises only `sel_idle`, which has no other effect. No other address from 0xA10000 to 0xBFFFFF raises a select, apart from the pages in R1, R4 and R9. This includes 0xA10100, 0xA11400, 0xA14004, 0xA14102, 0xB00000 and 0xBFFFFF.
- R4: The lock register spans 0xA14000 to 0xA14003, and `sel_lock` asserts for that range. Its write path is DATA_W bits wide. The word at byte offset 0 is the upper half of the key and the word at offset 2 is the lower half. It is released only while both halves together equal KEY. It powers up cleared. `sel_lock2` asserts only for 0xA14100 to 0xA14101.
- R5: While the lock is not released, any access with address bits 23:21 equal to 3'b110 latches a lockout, whether or not the address matches the mirror mask. `cpu_reset` and `cpu_halt` are then high from the second cycle after the access.
- R6: The access that triggers the lockout still produces its `sel_video` in the cycle before `cpu_reset` rises.
- R7: Once the lockout is latched, `cpu_halt` and `cpu_reset` stay high and all selects stay low. `rst_btn` does not change this.
- R8: With no lockout, `rst_btn` high at an edge drives `cpu_reset` high for the following cycle, and `cpu_halt` stays low.
- R9: `sel_exp` asserts for any access to page 0xA120xx. `exp_wr` asserts only for writes to that page.
- R10: Only `rst` clears the lockout and the lock register. During `rst`, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | 24 | CPU byte address |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | DATA_W | Write data |
| rst_btn | input | 1 | External reset-button request |
| sel_sound | output | 1 | Sound-CPU area select |
| sel_io | output | 1 | I/O chip select |
| sel_refresh | output | 1 | Memory refresh control select |
| sel_busreq | output | 1 | Sound-CPU bus-request register select |
| sel_sndrst | output | 1 | Sound-CPU reset register select |
| sel_idle | output | 1 | Decoded page with no effect |
| sel_exp | output | 1 | Expansion area select |
| exp_wr | output | 1 | Expansion area write strobe |
| sel_timer | output | 1 | Cartridge time area select |
| sel_lock | output | 1 | Lock register select |
| sel_lock2 | output | 1 | Second lock register select |
| sel_video | output | 1 | Video processor select |
| cpu_reset | output | 1 | CPU reset |
| cpu_halt | output | 1 | CPU halt |

## Verification
The bench builds the block with DATA_W = 16 and a two-word key of 0x5A3CC3A5. Releasing the lock therefore takes two separate writes, one to each half. This lets the bench show that writing only one correct half leaves the lock closed, and that corrupting a single half closes it again. With the default parameters, the bench triggers the lockout twice: once from a read that falls outside the mirror mask, and once from a write that hits it. It also holds the reset button during a lockout and checks that the lockout survives until power-on reset.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int ADDR_W = 24;
  localparam int PAGE_LSB = 8;

  typedef struct packed {
    logic sound;
    logic io;
    logic refresh;
    logic busreq;
    logic sndrst;
    logic idle;
    logic exp;
    logic exp_wr;
    logic timer;
    logic lock;
    logic lock2;
    logic video;
  } sel_t;

  localparam logic [ADDR_W-1:0] VID_MASK  = 24'hE700E0;
  localparam logic [ADDR_W-1:0] VID_MATCH = 24'hC00000;
endpackage

// File: rtl/io_page_decode.sv
module io_page_decode
  import io_dec_pkg::*;
#(
  parameter int LOCK_BYTES = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  input  logic              write,
  output sel_t              sel,
  output logic              vwin_hit
);
  localparam int PW = ADDR_W - PAGE_LSB;
  localparam logic [PW-1:0] PG_IO      = 16'hA100;
  localparam logic [PW-1:0] PG_REFRESH = 16'hA110;
  localparam logic [PW-1:0] PG_BUSREQ  = 16'hA111;
  localparam logic [PW-1:0] PG_SNDRST  = 16'hA112;
  localparam logic [PW-1:0] PG_IDLE    = 16'hA113;
  localparam logic [PW-1:0] PG_EXP     = 16'hA120;
  localparam logic [PW-1:0] PG_TIMER   = 16'hA130;
  localparam logic [PW-1:0] PG_LOCK    = 16'hA140;
  localparam logic [PW-1:0] PG_LOCK2   = 16'hA141;
  localparam logic [PAGE_LSB-1:0] LOCK_END = PAGE_LSB'(LOCK_BYTES);

  logic [PW-1:0] page;
  logic [PAGE_LSB-1:0] offs;

  assign page = addr[ADDR_W-1:PAGE_LSB];
  assign offs = addr[PAGE_LSB-1:0];

  always_comb begin
    sel         = '0;
    sel.sound   = valid && (addr[ADDR_W-1:16] == 8'hA0);
    sel.io      = valid && (page == PG_IO);
    sel.refresh = valid && (page == PG_REFRESH);
    sel.busreq  = valid && (page == PG_BUSREQ);
    sel.sndrst  = valid && (page == PG_SNDRST);
    sel.idle    = valid && (page == PG_IDLE);
    sel.exp     = valid && (page == PG_EXP);
    sel.exp_wr  = valid && write && (page == PG_EXP);
    sel.timer   = valid && (page == PG_TIMER);
    sel.lock    = valid && (page == PG_LOCK) && (offs < LOCK_END);
    sel.lock2   = valid && (page == PG_LOCK2) && (offs[PAGE_LSB-1:1] == '0);
    sel.video   = valid && ((addr & VID_MASK) == VID_MATCH);
  end

  assign vwin_hit = valid && (addr[ADDR_W-1:ADDR_W-3] == 3'b110);
endmodule

// File: rtl/io_lock_guard.sv
module io_lock_guard #(
  parameter int          DATA_W    = 16,
  parameter int          KEY_WORDS = 2,
  parameter logic [KEY_WORDS*DATA_W-1:0] KEY = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [7:0]        key_offs,
  input  logic [DATA_W-1:0] wdata,
  input  logic              vwin_hit,
  output logic              unlocked,
  output logic              locked_out
);
  localparam int KEY_W = KEY_WORDS * DATA_W;
  localparam int IDX_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;

  logic [IDX_W-1:0]  idx;
  logic [KEY_W-1:0]  key_flat;

  assign idx = key_offs[1 +: IDX_W];

  for (genvar w = 0; w < KEY_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)
        word_q <= '0;
      else if (key_wr && (idx == IDX_W'(w)))
        word_q <= wdata;
    end
    assign key_flat[KEY_W-1-w*DATA_W -: DATA_W] = word_q;
  end

  assign unlocked = (key_flat == KEY);

  always_ff @(posedge clk) begin
    if (rst)
      locked_out <= 1'b0;
    else if (vwin_hit && !unlocked)
      locked_out <= 1'b1;
  end
endmodule

// File: rtl/io_page_decoder.sv
module io_page_decoder
  import io_dec_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int KEY_WORDS = 2,
  parameter logic [KEY_WORDS*DATA_W-1:0] KEY = 32'h5A3C_C3A5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [23:0]       bus_addr,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              rst_btn,
  output logic              sel_sound,
  output logic              sel_io,
  output logic              sel_refresh,
  output logic              sel_busreq,
  output logic              sel_sndrst,
  output logic              sel_idle,
  output logic              sel_exp,
  output logic              exp_wr,
  output logic              sel_timer,
  output logic              sel_lock,
  output logic              sel_lock2,
  output logic              sel_video,
  output logic              cpu_reset,
  output logic              cpu_halt
);
  localparam int LOCK_BYTES = KEY_WORDS * (DATA_W / 8);

  sel_t dec_sel;
  sel_t sel_q;
  logic vwin_hit;
  logic unlocked;
  logic lockout;
  logic reset_q;
  logic halt_q;

  io_page_decode #(.LOCK_BYTES(LOCK_BYTES)) u_decode (
    .addr     (bus_addr),
    .valid    (bus_valid),
    .write    (bus_write),
    .sel      (dec_sel),
    .vwin_hit (vwin_hit)
  );

  io_lock_guard #(
    .DATA_W    (DATA_W),
    .KEY_WORDS (KEY_WORDS),
    .KEY       (KEY)
  ) u_guard (
    .clk        (clk),
    .rst        (rst),
    .key_wr     (dec_sel.lock && bus_write),
    .key_offs   (bus_addr[7:0]),
    .wdata      (bus_wdata),
    .vwin_hit   (vwin_hit),
    .unlocked   (unlocked),
    .locked_out (lockout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      reset_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      sel_q   <= lockout ? '0 : dec_sel;
      reset_q <= lockout | rst_btn;
      halt_q  <= lockout;
    end
  end

  assign sel_sound   = sel_q.sound;
  assign sel_io      = sel_q.io;
  assign sel_refresh = sel_q.refresh;
  assign sel_busreq  = sel_q.busreq;
  assign sel_sndrst  = sel_q.sndrst;
  assign sel_idle    = sel_q.idle;
  assign sel_exp     = sel_q.exp;
  assign exp_wr      = sel_q.exp_wr;
  assign sel_timer   = sel_q.timer;
  assign sel_lock    = sel_q.lock;
  assign sel_lock2   = sel_q.lock2;
  assign sel_video   = sel_q.video;
  assign cpu_reset   = reset_q;
  assign cpu_halt    = halt_q;
endmodule

// File: rtl/io_page_decoder_chk.sv
module io_page_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic [11:0] sels,
  input logic        sel_exp,
  input logic        exp_wr,
  input logic        lockout,
  input logic        cpu_reset,
  input logic        cpu_halt
);
  logic [10:0] exclusive;
  assign exclusive = {sels[11:5], sels[3:0]};

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(exclusive)); // R1

  AST_EXP_WR_SUBSET: assert property (@(posedge clk) disable iff (rst)
    exp_wr |-> sel_exp); // R9

  AST_LOCKOUT_TO_HALT: assert property (@(posedge clk) disable iff (rst)
    $rose(lockout) |=> cpu_halt); // R5

  AST_HALT_HAS_RESET: assert property (@(posedge clk) disable iff (rst)
    cpu_halt |-> cpu_reset); // R5

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    cpu_halt |=> cpu_halt); // R7

  AST_QUIET_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
    cpu_halt |-> (sels == '0)); // R7
endmodule

bind io_page_decoder io_page_decoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sels      (sel_q),
  .sel_exp   (sel_exp),
  .exp_wr    (exp_wr),
  .lockout   (lockout),
  .cpu_reset (cpu_reset),
  .cpu_halt  (cpu_halt)
);

// File: tb/io_page_decoder_test.sv
module io_page_decoder_test;
  localparam int CLK_NS = 5;
  localparam logic [31:0] KEY = 32'h5A3C_C3A5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] bus_addr = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        rst_btn = 1'b0;
  logic sel_sound, sel_io, sel_refresh, sel_busreq, sel_sndrst, sel_idle;
  logic sel_exp, exp_wr, sel_timer, sel_lock, sel_lock2, sel_video;
  logic cpu_reset, cpu_halt;

  always #(CLK_NS / 2.0) clk = ~clk;

  io_page_decoder #(.DATA_W(16), .KEY_WORDS(2), .KEY(KEY)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .rst_btn(rst_btn),
    .sel_sound(sel_sound), .sel_io(sel_io), .sel_refresh(sel_refresh),
    .sel_busreq(sel_busreq), .sel_sndrst(sel_sndrst), .sel_idle(sel_idle),
    .sel_exp(sel_exp), .exp_wr(exp_wr), .sel_timer(sel_timer),
    .sel_lock(sel_lock), .sel_lock2(sel_lock2), .sel_video(sel_video),
    .cpu_reset(cpu_reset), .cpu_halt(cpu_halt)
  );

  typedef struct {
    logic [13:0] exp;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [15:0] m_key [2];
  logic        m_lock = 1'b0;

  // Expected selects from the requirement address map
  // order: sound io refresh busreq sndrst idle exp exp_wr timer lock lock2 video
  function automatic logic [11:0] model_sel(logic [23:0] a, logic v, logic w);
    logic [11:0] s;
    s = '0;
    if (v) begin
      s[11] = (a >= 24'hA00000) && (a <= 24'hA0FFFF);
      s[10] = (a >= 24'hA10000) && (a <= 24'hA100FF);
      s[9]  = (a >= 24'hA11000) && (a <= 24'hA110FF);
      s[8]  = (a >= 24'hA11100) && (a <= 24'hA111FF);
      s[7]  = (a >= 24'hA11200) && (a <= 24'hA112FF);
      s[6]  = (a >= 24'hA11300) && (a <= 24'hA113FF);
      s[5]  = (a >= 24'hA12000) && (a <= 24'hA120FF);
      s[4]  = s[5] && w;
      s[3]  = (a >= 24'hA13000) && (a <= 24'hA130FF);
      s[2]  = (a >= 24'hA14000) && (a <= 24'hA14003);
      s[1]  = (a >= 24'hA14100) && (a <= 24'hA14101);
      s[0]  = (a & 24'hE700E0) == 24'hC00000;
    end
    return s;
  endfunction

  task automatic drive(input logic [23:0] a, input logic v, input logic w,
                       input logic [15:0] d, input logic btn, input string tag);
    item_t it;
    logic  unl;
    @(negedge clk);
    bus_addr = a; bus_valid = v; bus_write = w; bus_wdata = d; rst_btn = btn;
    it.exp = {m_lock ? 12'h000 : model_sel(a, v, w), m_lock | btn, m_lock};
    it.tag = tag;
    sb.push_back(it);
    unl = ({m_key[0], m_key[1]} == KEY);
    if (v && w && a >= 24'hA14000 && a <= 24'hA14003) m_key[a[1]] = d;
    if (v && a[23:21] == 3'b110 && !unl) m_lock = 1'b1;
  endtask

  task automatic idle(input logic btn, input string tag);
    drive(24'h000000, 1'b0, 1'b0, 16'h0, btn, tag);
  endtask

  task automatic power_reset(input string tag);
    item_t it;
    @(negedge clk);
    rst = 1'b1; bus_valid = 1'b0; rst_btn = 1'b0;
    m_key[0] = '0; m_key[1] = '0; m_lock = 1'b0;
    it.exp = '0; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    sb.push_back(it);
    rst = 1'b0;
  endtask

  // Monitor: compares registered outputs just after each rising edge
  always @(posedge clk) begin
    item_t it;
    logic [13:0] act;
    #1;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      act = {sel_sound, sel_io, sel_refresh, sel_busreq, sel_sndrst, sel_idle,
             sel_exp, exp_wr, sel_timer, sel_lock, sel_lock2, sel_video,
             cpu_reset, cpu_halt};
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #(CLK_NS * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    power_reset("R10 reset state");
    drive(24'hA10000, 1'b0, 1'b0, 16'h0, 1'b0, "R1 no strobe");
    drive(24'hA00000, 1'b1, 1'b0, 16'h0, 1'b0, "R1 sound low");
    drive(24'hA0FFFF, 1'b1, 1'b1, 16'h0, 1'b0, "R1 sound high");
    drive(24'hA10000, 1'b1, 1'b0, 16'h0, 1'b0, "R1 io");
    drive(24'hA100FF, 1'b1, 1'b1, 16'h0, 1'b0, "R1 io page end");
    drive(24'hA11000, 1'b1, 1'b1, 16'h0, 1'b0, "R1 refresh");
    drive(24'hA11180, 1'b1, 1'b0, 16'h0, 1'b0, "R1 busreq");
    drive(24'hA11200, 1'b1, 1'b1, 16'h0, 1'b0, "R1 sndrst");
    drive(24'hA130FE, 1'b1, 1'b0, 16'h0, 1'b0, "R1 timer");
    drive(24'hA11300, 1'b1, 1'b1, 16'h0, 1'b0, "R3 idle page");
    drive(24'hA12000, 1'b1, 1'b0, 16'h0, 1'b0, "R9 expansion read");
    drive(24'hA12010, 1'b1, 1'b1, 16'h0, 1'b0, "R9 expansion write");
    drive(24'hA14003, 1'b1, 1'b0, 16'h0, 1'b0, "R4 lock select");
    drive(24'hA14100, 1'b1, 1'b0, 16'h0, 1'b0, "R4 second lock");
    drive(24'hA14004, 1'b1, 1'b1, 16'hFFFF, 1'b0, "R3 past lock");
    drive(24'hA14102, 1'b1, 1'b0, 16'h0, 1'b0, "R3 past lock2");
    drive(24'hA10100, 1'b1, 1'b0, 16'h0, 1'b0, "R3 unused");
    drive(24'hA11400, 1'b1, 1'b0, 16'h0, 1'b0, "R3 unused");
    drive(24'hB00000, 1'b1, 1'b1, 16'h0, 1'b0, "R3 unused");
    drive(24'hBFFFFF, 1'b1, 1'b0, 16'h0, 1'b0, "R3 unused");
    // unlock in two halves
    drive(24'hA14000, 1'b1, 1'b1, KEY[31:16], 1'b0, "R4 key upper");
    drive(24'hA14002, 1'b1, 1'b1, KEY[15:0], 1'b0, "R4 key lower");
    drive(24'hC00000, 1'b1, 1'b1, 16'h8C8F, 1'b0, "R2 video base");
    drive(24'hC80000, 1'b1, 1'b0, 16'h0, 1'b0, "R2 mirror");
    drive(24'hD00000, 1'b1, 1'b0, 16'h0, 1'b0, "R2 mirror");
    drive(24'hD8001F, 1'b1, 1'b1, 16'h0, 1'b0, "R2 mirror");
    drive(24'hC00020, 1'b1, 1'b0, 16'h0, 1'b0, "R2 non-mirror");
    drive(24'hE00000, 1'b1, 1'b0, 16'h0, 1'b0, "R2 outside window");
    idle(1'b1, "R8 button pulse");
    idle(1'b0, "R8 button released");
    // relock by corrupting one half, then hit a non-mirror address
    drive(24'hA14002, 1'b1, 1'b1, 16'h0001, 1'b0, "R4 key corrupt");
    drive(24'hA10000, 1'b1, 1'b0, 16'h0, 1'b0, "R1 still clear");
    drive(24'hC00020, 1'b1, 1'b0, 16'h0, 1'b0, "R5 trigger non-mirror");
    idle(1'b0, "R5 held");
    idle(1'b1, "R7 button ignored");
    idle(1'b1, "R7 button ignored");
    idle(1'b0, "R7 still held");
    drive(24'hA10000, 1'b1, 1'b0, 16'h0, 1'b0, "R7 selects blocked");
    power_reset("R10 clears lockout");
    drive(24'hA14000, 1'b1, 1'b1, KEY[31:16], 1'b0, "R4 half key only");
    drive(24'hC00004, 1'b1, 1'b1, 16'h1234, 1'b0, "R6 write lands");
    idle(1'b0, "R5 halt after write");
    idle(1'b0, "R7 sticky");
    power_reset("R10 final reset");
    idle(1'b0, "R10 quiet");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule